// File: doc/BRIEF.md
# Counter Overflow Interrupt Controller

This block gathers single-cycle overflow pulses from sixteen general event counters and eight bandwidth counters. Each pulse sets a sticky bit in a 24-bit status vector. A 24-bit enable mask selects which latched bits may raise the single level-sensitive interrupt line. Software reaches the block through a 32-bit register port.

Software changes the enable mask only through two write-one registers, one that sets bits and one that clears them. A third register reads the mask back. Latched status is read from one register and cleared bit by bit through another. The bandwidth-counter overflows occupy the eight low status bits. The general counters sit above them, in bits 23:8.

The register port is a request/response stream pair. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, yields exactly one response beat. `req_ready` is high whenever no response is pending or the pending one is being taken that cycle. This lets a new request be accepted in the same cycle the previous response is consumed. While `rsp_valid` is high and `rsp_ready` is low, the response data is held unchanged and no new request is accepted.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: After reset the enable mask and the status vector are all zero, `irq` is low and `rsp_valid` is low.
- R2: A high on `bw_ovf[j]` sets status bit j. A high on `cnt_ovf[k]` sets status bit 8+k. The bit is set on the clock edge where the pulse is sampled, whatever the enable mask holds, and it stays set until software clears it.
- R3: A write to offset 0xCB8 sets every enable bit whose write-data bit (23:0) is one. Bits written as zero keep their value.
- R4: A write to offset 0xCBC clears every enable bit whose write-data bit (23:0) is one. Other enable bits keep their value.
- R5: A read of offset 0xCC0 returns the enable mask in bits 23:0, with bits 31:24 reading zero.
- R6: A write to offset 0xCC4 clears every status bit whose write-data bit is one. Writing 0x00FFFFFF clears all status bits.
- R7: A read of offset 0xCC8 returns the status vector in bits 23:0, with bits 31:24 reading zero.
- R8: If an overflow pulse and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when the bitwise AND of status and enable is non-zero. It follows the registered state with no further delay, so it changes in the cycle after the edge that updated status or enable.
- R10: Each accepted request produces one response, with `req_ready = !rsp_valid || rsp_ready`. Read data is the register value just before the accepting edge, and a write's response data is zero. While the response is stalled, `rsp_valid` stays high and `rsp_rdata` holds steady.
- R11: Write-data bits 31:24 have no effect. Writes to any offset other than 0xCB8, 0xCBC and 0xCC4 change nothing. Reads of any offset other than 0xCC0 and 0xCC8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_ovf | input | 8 | Bandwidth counter overflow pulses (status bits 7:0) |
| cnt_ovf | input | 16 | General counter overflow pulses (status bits 23:8) |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions take the overflow inputs to be synchronous to `clk` and sampled once per edge. They take the request fields to be meaningful only while `req_valid` is high and to stay steady while a request waits for `req_ready`. The stall check also assumes `rsp_ready` may drop at any time without harm. The stimulus changes every input half a cycle away from the active edge and holds a waiting request unchanged through a back-pressure stall. Each pulse is raised for exactly one cycle, except where a collision with a clear write is deliberately staged in the same cycle.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_ENA_SET = 12'hCB8;
  localparam logic [ADDR_W-1:0] OFS_ENA_CLR = 12'hCBC;
  localparam logic [ADDR_W-1:0] OFS_ENA_RD  = 12'hCC0;
  localparam logic [ADDR_W-1:0] OFS_STS_CLR = 12'hCC4;
  localparam logic [ADDR_W-1:0] OFS_STS_RD  = 12'hCC8;

  typedef struct packed {
    logic ena_set;
    logic ena_clr;
    logic sts_clr;
  } wr_strobe_t;
endpackage

// File: rtl/ovf_reg_decode.sv
module ovf_reg_decode
  import ovf_irq_pkg::*;
#(
  parameter int NSRC = 24
) (
  input  logic              acc,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   en_vec,
  input  logic [NSRC-1:0]   sts_vec,
  output wr_strobe_t        strb,
  output logic [NSRC-1:0]   wmask,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:NSRC];
  assign wmask = wdata[NSRC-1:0];

  always_comb begin
    strb = '0;
    if (acc && wr) begin
      strb.ena_set = (addr == OFS_ENA_SET);
      strb.ena_clr = (addr == OFS_ENA_CLR);
      strb.sts_clr = (addr == OFS_STS_CLR);
    end
  end

  always_comb begin
    rdata = '0;
    if (!wr) begin
      if (addr == OFS_ENA_RD) rdata[NSRC-1:0] = en_vec;
      else if (addr == OFS_STS_RD) rdata[NSRC-1:0] = sts_vec;
    end
  end
endmodule

// File: rtl/ovf_enable_mask.sv
module ovf_enable_mask #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wmask,
  output logic [NSRC-1:0] en_vec
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) en_vec[i] <= 1'b0;
      else if (set_we && wmask[i]) en_vec[i] <= 1'b1;
      else if (clr_we && wmask[i]) en_vec[i] <= 1'b0;
    end

    // R3
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && wmask[i]) |=> en_vec[i]);
    // R4
    ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we && wmask[i]) |=> !en_vec[i]);
  end
endmodule

// File: rtl/ovf_status_bank.sv
module ovf_status_bank #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pulse,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wmask,
  output logic [NSRC-1:0] sts_vec
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) sts_vec[i] <= 1'b0;
      else if (pulse[i]) sts_vec[i] <= 1'b1;
      else if (clr_we && wmask[i]) sts_vec[i] <= 1'b0;
    end

    // R2 R8
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> sts_vec[i]);
    // R6
    sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wmask[i] && !pulse[i]) |=> !sts_vec[i]);
    // R2
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_vec[i] && !(clr_we && wmask[i])) |=> sts_vec[i]);
    // R2
    sts_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_vec[i] && !pulse[i]) |=> !sts_vec[i]);
  end
endmodule

// File: rtl/ovf_rsp_stage.sv
module ovf_rsp_stage
  import ovf_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              acc,
  input  logic              wr,
  input  logic [DATA_W-1:0] rd_next,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= wr ? '0 : rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R10
  rsp_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl
  import ovf_irq_pkg::*;
#(
  parameter int NUM_BW  = 8,
  parameter int NUM_CNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BW-1:0] bw_ovf,
  input  logic [NUM_CNT-1:0] cnt_ovf,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int NSRC = NUM_BW + NUM_CNT;

  logic [NSRC-1:0]   pulse_vec;
  logic [NSRC-1:0]   en_vec;
  logic [NSRC-1:0]   sts_vec;
  logic [NSRC-1:0]   wmask;
  logic [DATA_W-1:0] rd_next;
  logic              acc;
  wr_strobe_t        strb;

  assign pulse_vec = {cnt_ovf, bw_ovf};

  ovf_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .acc(acc), .wr(req_write), .rd_next(rd_next), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  ovf_reg_decode #(.NSRC(NSRC)) u_dec (
    .acc(acc), .wr(req_write), .addr(req_addr), .wdata(req_wdata),
    .en_vec(en_vec), .sts_vec(sts_vec), .strb(strb), .wmask(wmask),
    .rdata(rd_next)
  );

  ovf_enable_mask #(.NSRC(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .set_we(strb.ena_set), .clr_we(strb.ena_clr),
    .wmask(wmask), .en_vec(en_vec)
  );

  ovf_status_bank #(.NSRC(NSRC)) u_sts (
    .clk(clk), .rst_n(rst_n), .pulse(pulse_vec), .clr_we(strb.sts_clr),
    .wmask(wmask), .sts_vec(sts_vec)
  );

  assign irq = |(sts_vec & en_vec);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|pulse_vec) || $past(strb.ena_set)));
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(strb.ena_clr) || $past(strb.sts_clr)));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && req_write) |=> ($stable(en_vec) && ((sts_vec & ~$past(sts_vec | pulse_vec)) == '0)));
endmodule

// File: tb/sim_ovf_irq_ctrl.sv
module sim_ovf_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bw_ovf = '0;
  logic [15:0] cnt_ovf = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  localparam logic [11:0] A_ESET = 12'hCB8, A_ECLR = 12'hCBC, A_ERD = 12'hCC0,
                          A_SCLR = 12'hCC4, A_SRD = 12'hCC8;

  always #2 clk = ~clk;

  ovf_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bw_ovf(bw_ovf), .cnt_ovf(cnt_ovf),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    q = rsp_rdata;
  endtask

  task automatic pulse(input logic [7:0] b, input logic [15:0] c);
    @(negedge clk);
    bw_ovf = b; cnt_ovf = c;
    @(negedge clk);
    bw_ovf = '0; cnt_ovf = '0;
  endtask

  task automatic t_reset();
    logic [31:0] q;
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus(1'b0, A_ERD, 32'h0, q);
    chk("R1 enable after reset", q, 32'h0);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R1 status after reset", q, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] q;
    pulse(8'h08, 16'h0020);
    chk("R9 irq low while disabled", {31'b0, irq}, 32'h0);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R2 R7 status after pulses", q, 32'h0000_2008);
    repeat (5) @(negedge clk);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R2 status sticky", q, 32'h0000_2008);
  endtask

  task automatic t_enable();
    logic [31:0] q;
    bus(1'b1, A_ESET, 32'hFF00_2000, q);
    chk("R10 write response zero", q, 32'h0);
    chk("R9 irq high after enable", {31'b0, irq}, 32'h1);
    bus(1'b0, A_ERD, 32'h0, q);
    chk("R3 R5 R11 enable set, upper ignored", q, 32'h0000_2000);
    bus(1'b1, A_ESET, 32'h0000_0001, q);
    bus(1'b0, A_ERD, 32'h0, q);
    chk("R3 zeros leave bits", q, 32'h0000_2001);
    bus(1'b1, A_ECLR, 32'h0000_2000, q);
    chk("R9 irq low after disable", {31'b0, irq}, 32'h0);
    bus(1'b0, A_ERD, 32'h0, q);
    chk("R4 enable clear", q, 32'h0000_0001);
  endtask

  task automatic t_clear();
    logic [31:0] q;
    bus(1'b1, A_SCLR, 32'h0000_0008, q);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R6 partial clear", q, 32'h0000_2000);
    pulse(8'hFF, 16'hFFFF);
    chk("R9 irq on enabled bit0", {31'b0, irq}, 32'h1);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R2 all bits set", q, 32'h00FF_FFFF);
    bus(1'b1, A_SCLR, 32'h00FF_FFFF, q);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R6 clear all", q, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] q;
    @(negedge clk);
    cnt_ovf = 16'h0001;
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_SCLR; req_wdata = 32'h0000_0100;
    @(negedge clk);
    cnt_ovf = '0; req_valid = 1'b0; req_write = 1'b0;
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R8 set wins over clear", q, 32'h0000_0100);
  endtask

  task automatic t_unmapped();
    logic [31:0] q;
    bus(1'b0, 12'h000, 32'h0, q);
    chk("R11 unmapped read", q, 32'h0);
    bus(1'b1, 12'hCB4, 32'h00FF_FFFF, q);
    bus(1'b1, A_SRD, 32'h00FF_FFFF, q);
    bus(1'b0, A_ERD, 32'h0, q);
    chk("R11 unmapped write leaves enable", q, 32'h0000_0001);
    bus(1'b0, A_SRD, 32'h0, q);
    chk("R11 write to status read leaves status", q, 32'h0000_0100);
    bus(1'b0, A_ESET, 32'h0, q);
    chk("R11 write-only offset reads zero", q, 32'h0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_ERD;
    @(negedge clk);
    chk("R10 response valid", {31'b0, rsp_valid}, 32'h1);
    chk("R10 first read data", rsp_rdata, 32'h0000_0001);
    req_addr = A_SRD;
    @(negedge clk);
    chk("R10 ready low while stalled", {31'b0, req_ready}, 32'h0);
    chk("R10 data held while stalled", rsp_rdata, 32'h0000_0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second response valid", {31'b0, rsp_valid}, 32'h1);
    chk("R10 second read data", rsp_rdata, 32'h0000_0100);
    @(negedge clk);
    chk("R10 response drained", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sticky();
    t_enable();
    t_clear();
    t_set_wins();
    t_unmapped();
    t_backpressure();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule